// File: doc/BRIEF.md
# Receive Buffer Flow-Control Controller

This block sits between a serial receiver/transmitter pair and the rest of the system. Every character the receiver delivers is stored in a small first-in first-out buffer. The application drains that buffer through a read port. When the buffer starts to fill, the block asks the remote sender to pause. In software mode it injects an XOFF character ahead of any queued transmit data. In hardware mode it raises an RTS level. Once the application has drained the buffer back down to a single character, the block lets the sender resume: it injects XON, or it drives RTS low again.

The block also decides whether the local transmitter may start the next queued character, reported on `tx_allow`. In software mode, received XON and XOFF characters turn this permission on and off, and they are never written into the buffer. In CTS mode, the permission follows an active-low CTS input, and the receive path is ignored.

Flow control is a four-state machine:
- `TH_OPEN`: the buffer is accepting freely.
- `TH_XOFF_PEND`: XOFF is owed and waits for the transmitter to go idle.
- `TH_HELD`: the sender is throttled.
- `TH_XON_PEND`: XON is owed and waits for the transmitter to go idle.

The transitions are:
- stop-software (`TH_OPEN` to `TH_XOFF_PEND`)
- stop-hardware (`TH_OPEN` to `TH_HELD`)
- xoff-sent (`TH_XOFF_PEND` to `TH_HELD`)
- resume-software (`TH_HELD` to `TH_XON_PEND`)
- resume-hardware (`TH_HELD` to `TH_OPEN`)
- xon-sent (`TH_XON_PEND` to `TH_OPEN`)
- mode-off: any state goes to `TH_OPEN` when neither software nor hardware mode is selected.

Top module: `rx_flow_ctrl`

## Requirements
- R1: After reset the buffer level is 0, the overrun flag is 0, `rts_n` is 0, `inj_valid` is 0 and `tx_allow` is 1.
- R2: Characters written to the buffer are read back in arrival order. A read (`rd_en` high for one cycle) updates `rd_data` on the following clock, and `fifo_level` tracks the number of stored characters.
- R3: A write while 8 characters are stored is dropped and sets the sticky `overrun` flag. The level never exceeds 8.
- R4: A read while the buffer is empty loads 0x00 into `rd_data`.
- R5: In software mode (`hs_mode` bit 2), once the level reaches 2, an XOFF (0x13) is owed. It is presented on `inj_valid`/`inj_char` for exactly one cycle, and only in a cycle where `tx_idle` is high.
- R6: In software mode, after XOFF was sent and the level falls to 1 or below, an XON (0x11) is presented the same way, and the machine returns to `TH_OPEN`.
- R7: In hardware mode (`hs_mode` bit 0, software mode off), `rts_n` goes high the cycle after the level reaches 5. It goes low again the cycle after the level falls to 1 or below.
- R8: In software mode, a received 0x13 clears transmit permission and a received 0x11 sets it. Neither is stored. Outside software mode, both are stored as ordinary data.
- R9: In CTS mode (`hs_mode` bit 1), `tx_allow` is the inverse of `cts_n`, and received characters are neither stored nor acted on.
- R10: While an XON or XOFF is owed, `tx_allow` is low, so the injected character goes out ahead of queued data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_mode | input | 3 | Handshake select: bit 0 hardware RTS, bit 1 CTS, bit 2 software XON/XOFF |
| rx_valid | input | 1 | One-cycle strobe, a received character is on rx_data |
| rx_data | input | 8 | Received character |
| rd_en | input | 1 | Application read strobe |
| rd_data | output | 8 | Character read by the last strobe (0 if the buffer was empty) |
| fifo_level | output | 4 | Number of stored characters |
| overrun | output | 1 | Sticky flag: a write was dropped |
| tx_idle | input | 1 | Local transmitter is idle |
| inj_valid | output | 1 | One-cycle request to transmit inj_char now |
| inj_char | output | 8 | Flow-control character to inject (0x11 or 0x13) |
| cts_n | input | 1 | Active-low clear-to-send from the remote side |
| tx_allow | output | 1 | Local transmitter may start the next queued character |
| rts_n | output | 1 | Active-low request-to-send to the remote side |

## Verification
The assertions assume that `hs_mode` changes only while the machine is in `TH_OPEN` with an empty buffer. For example, the RTS rise check presumes hardware mode was not switched on while a software-mode hold was in progress. The stimulus therefore drains the buffer and lets any owed XON go out before it changes mode. It also assumes `rx_valid` and `rd_en` are single-cycle strobes driven synchronously. The bench drives all inputs on the falling edge and compares against its queue-based model half a cycle later.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
    typedef enum logic [1:0] {
        TH_OPEN      = 2'd0,
        TH_XOFF_PEND = 2'd1,
        TH_HELD      = 2'd2,
        TH_XON_PEND  = 2'd3
    } th_state_t;

    localparam logic [7:0] CH_XON  = 8'h11;
    localparam logic [7:0] CH_XOFF = 8'h13;

    localparam int MB_RTS = 0;
    localparam int MB_CTS = 1;
    localparam int MB_SW  = 2;
endpackage

// File: rtl/rfc_fifo.sv
module rfc_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic [CW-1:0] level,
    output logic          overrun
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, empty, do_push, do_pop;

    function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp       <= '0;
            rp       <= '0;
            level    <= '0;
            pop_data <= '0;
            overrun  <= 1'b0;
        end else begin
            if (do_push) wp <= nxt_ptr(wp);
            if (pop) begin
                pop_data <= empty ? '0 : mem[rp];
                if (!empty) rp <= nxt_ptr(rp);
            end
            level   <= level + CW'(do_push) - CW'(do_pop);
            overrun <= overrun | (push && full);
        end
    end

    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
    p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (overrun && level == CW'(DEPTH) - CW'($past(pop))));
    p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (pop_data == '0));
endmodule

// File: rtl/rfc_throttle.sv
module rfc_throttle
    import rfc_pkg::*;
#(
    parameter int CW      = 4,
    parameter int STOP_SW = 2,
    parameter int STOP_HW = 5,
    parameter int RESUME  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_mode,
    input  logic          hw_mode,
    input  logic [CW-1:0] level,
    input  logic          tx_idle,
    output logic          inj_valid,
    output logic [7:0]    inj_char,
    output logic          inj_pend,
    output logic          rts_n
);
    th_state_t st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TH_OPEN;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            TH_OPEN: begin
                if (sw_mode) begin
                    if (level >= CW'(STOP_SW)) nxt = TH_XOFF_PEND;
                end else if (hw_mode && level >= CW'(STOP_HW)) begin
                    nxt = TH_HELD;
                end
            end
            TH_XOFF_PEND: if (tx_idle) nxt = TH_HELD;
            TH_HELD:      if (level <= CW'(RESUME)) nxt = sw_mode ? TH_XON_PEND : TH_OPEN;
            TH_XON_PEND:  if (tx_idle) nxt = TH_OPEN;
            default:      nxt = TH_OPEN;
        endcase
        if (!sw_mode && !hw_mode) nxt = TH_OPEN;
    end

    always_comb begin
        inj_pend  = (st == TH_XOFF_PEND) || (st == TH_XON_PEND);
        inj_valid = inj_pend && tx_idle;
        inj_char  = (st == TH_XON_PEND) ? CH_XON : CH_XOFF;
        rts_n     = hw_mode && !sw_mode && (st == TH_HELD);
    end

    p_inj_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> tx_idle);
    p_inj_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |=> !inj_valid);
    p_rts_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts_n) |-> ($past(level) >= CW'(STOP_HW)));
    p_rts_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rts_n) && hw_mode) |-> ($past(level) <= CW'(RESUME)));
endmodule

// File: rtl/rfc_tx_gate.sv
module rfc_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_mode,
    input  logic cts_mode,
    input  logic cts_n,
    input  logic saw_xon,
    input  logic saw_xoff,
    input  logic inj_pend,
    output logic tx_allow
);
    logic tx_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        tx_en <= 1'b1;
        else if (saw_xon)  tx_en <= 1'b1;
        else if (saw_xoff) tx_en <= 1'b0;
    end

    assign tx_allow = (!sw_mode || tx_en) && (!cts_mode || !cts_n) && !inj_pend;
endmodule

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl
    import rfc_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int STOP_SW = 2,
    parameter int STOP_HW = 5,
    parameter int RESUME  = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   hs_mode,
    input  logic                         rx_valid,
    input  logic [7:0]                   rx_data,
    input  logic                         rd_en,
    output logic [7:0]                   rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   fifo_level,
    output logic                         overrun,
    input  logic                         tx_idle,
    output logic                         inj_valid,
    output logic [7:0]                   inj_char,
    input  logic                         cts_n,
    output logic                         tx_allow,
    output logic                         rts_n
);
    localparam int CW = $clog2(DEPTH + 1);

    logic sw_mode, hw_mode, cts_mode;
    logic rx_take, is_xon, is_xoff, push, inj_pend;

    assign sw_mode  = hs_mode[MB_SW];
    assign hw_mode  = hs_mode[MB_RTS];
    assign cts_mode = hs_mode[MB_CTS];

    assign rx_take = rx_valid && !cts_mode;
    assign is_xon  = rx_take && sw_mode && (rx_data == CH_XON);
    assign is_xoff = rx_take && sw_mode && (rx_data == CH_XOFF);
    assign push    = rx_take && !is_xon && !is_xoff;

    rfc_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(rx_data),
        .pop(rd_en), .pop_data(rd_data),
        .level(fifo_level), .overrun(overrun)
    );

    rfc_throttle #(.CW(CW), .STOP_SW(STOP_SW), .STOP_HW(STOP_HW), .RESUME(RESUME)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sw_mode(sw_mode), .hw_mode(hw_mode),
        .level(fifo_level), .tx_idle(tx_idle),
        .inj_valid(inj_valid), .inj_char(inj_char),
        .inj_pend(inj_pend), .rts_n(rts_n)
    );

    rfc_tx_gate u_gate (
        .clk(clk), .rst_n(rst_n),
        .sw_mode(sw_mode), .cts_mode(cts_mode), .cts_n(cts_n),
        .saw_xon(is_xon), .saw_xoff(is_xoff),
        .inj_pend(inj_pend), .tx_allow(tx_allow)
    );

    p_inj_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> !tx_allow);
    p_ctl_strip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cts_mode && sw_mode && !rd_en &&
         (rx_data == CH_XON || rx_data == CH_XOFF)) |=> $stable(fifo_level));
    p_xoff_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cts_mode && sw_mode && rx_data == CH_XOFF) |=> !tx_allow);
    p_cts_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_mode && rx_valid && !rd_en) |=> $stable(fifo_level));
endmodule

// File: tb/tb_rx_flow_ctrl.sv
module tb_rx_flow_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hs_mode = 3'b000;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rd_en = 1'b0;
    logic       tx_idle = 1'b0;
    logic       cts_n = 1'b1;
    logic [7:0] rd_data, inj_char;
    logic [3:0] fifo_level;
    logic       overrun, inj_valid, tx_allow, rts_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rx_flow_ctrl dut (
        .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_level(fifo_level),
        .overrun(overrun), .tx_idle(tx_idle),
        .inj_valid(inj_valid), .inj_char(inj_char),
        .cts_n(cts_n), .tx_allow(tx_allow), .rts_n(rts_n)
    );

    // Reference model: 0 open, 1 xoff owed, 2 held, 3 xon owed
    int  q[$];
    int  mst = 0;
    bit  mtxen = 1;
    bit  movr = 0;
    int  mrd = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); mst = 0; mtxen = 1; movr = 0; mrd = 0;
        end else begin
            int  lvl;
            bit  swm, hwm, ctm;
            lvl = q.size();
            swm = hs_mode[2]; hwm = hs_mode[0]; ctm = hs_mode[1];
            if (rd_en) begin
                if (q.size() > 0) mrd = q.pop_front();
                else              mrd = 0;
            end
            if (rx_valid && !ctm) begin
                if (swm && rx_data == 8'h11)      mtxen = 1;
                else if (swm && rx_data == 8'h13) mtxen = 0;
                else if (lvl == 8)                movr = 1;
                else                              q.push_back(int'(rx_data));
            end
            case (mst)
                0: if (swm) begin if (lvl >= 2) mst = 1; end
                   else if (hwm && lvl >= 5) mst = 2;
                1: if (tx_idle) mst = 2;
                2: if (lvl <= 1) mst = swm ? 3 : 0;
                default: if (tx_idle) mst = 0;
            endcase
            if (!swm && !hwm) mst = 0;
        end
    end

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit pend, eallow;
        pend   = (mst == 1) || (mst == 3);
        eallow = (!hs_mode[2] || mtxen) && (!hs_mode[1] || !cts_n) && !pend;
        chk("R2/R3/R9", "fifo_level", int'(fifo_level), q.size());
        chk("R2/R4", "rd_data", int'(rd_data), mrd);
        chk("R3", "overrun", int'(overrun), int'(movr));
        chk("R5/R6", "inj_valid", int'(inj_valid), int'(pend && tx_idle));
        if (pend && tx_idle)
            chk("R5/R6", "inj_char", int'(inj_char), (mst == 3) ? 32'h11 : 32'h13);
        chk("R7", "rts_n", int'(rts_n), int'(hs_mode[0] && !hs_mode[2] && mst == 2));
        chk("R8/R9/R10", "tx_allow", int'(tx_allow), int'(eallow));
    endtask

    task automatic tick();
        #1 compare();
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b; tick(); rx_valid = 1'b0;
    endtask

    task automatic rd();
        rd_en = 1'b1; tick(); rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        idle(2);
        // R1: reset values
        chk("R1", "reset level", int'(fifo_level), 0);
        chk("R1", "reset rts_n", int'(rts_n), 0);
        chk("R1", "reset tx_allow", int'(tx_allow), 1);
        chk("R1", "reset inj_valid", int'(inj_valid), 0);
        rst_n = 1'b1;
        idle(2);

        // R2, R4, R8 outside software mode: order, empty read, control chars stored
        send(8'hA5); send(8'h11); send(8'h3C); send(8'h13);
        chk("R8", "ctl chars stored as data", int'(fifo_level), 4);
        rd(); rd(); rd(); rd();
        rd();
        idle(1);
        chk("R4", "empty read zero", int'(rd_data), 0);

        // R9: CTS mode
        hs_mode = 3'b010; cts_n = 1'b1; idle(1);
        chk("R9", "cts high blocks tx", int'(tx_allow), 0);
        cts_n = 1'b0; idle(1);
        chk("R9", "cts low allows tx", int'(tx_allow), 1);
        send(8'h55); send(8'h13);
        chk("R9", "rx ignored in cts mode", int'(fifo_level), 0);
        cts_n = 1'b1; hs_mode = 3'b000; idle(2);

        // R5, R6, R8, R10: software mode
        hs_mode = 3'b100; tx_idle = 1'b0;
        send(8'h21); send(8'h22); idle(3);
        chk("R10", "xoff owed blocks tx", int'(tx_allow), 0);
        chk("R5", "no inject while busy", int'(inj_valid), 0);
        tx_idle = 1'b1; #1;
        chk("R5", "xoff inject", int'(inj_valid), 1);
        chk("R5", "xoff char", int'(inj_char), 8'h13);
        @(negedge clk);
        idle(2);
        send(8'h13); idle(1);
        chk("R8", "xoff received gates tx", int'(tx_allow), 0);
        chk("R8", "xoff not stored", int'(fifo_level), 2);
        send(8'h11); idle(1);
        chk("R8", "xon received frees tx", int'(tx_allow), 1);
        tx_idle = 1'b0;
        rd(); idle(2);
        chk("R6", "xon owed", int'(tx_allow), 0);
        tx_idle = 1'b1; #1;
        chk("R6", "xon char", int'(inj_char), 8'h11);
        @(negedge clk);
        idle(2);
        rd(); idle(2);
        hs_mode = 3'b000; idle(2);

        // R7: hardware mode
        hs_mode = 3'b001;
        send(8'h01); send(8'h02); send(8'h11); send(8'h04);
        idle(2);
        chk("R7", "rts low below stop", int'(rts_n), 0);
        send(8'h05); idle(2);
        chk("R7", "rts high at stop", int'(rts_n), 1);
        rd(); rd(); rd(); idle(2);
        chk("R7", "rts still high at 2", int'(rts_n), 1);
        rd(); idle(2);
        chk("R7", "rts low at resume", int'(rts_n), 0);
        rd(); hs_mode = 3'b000; idle(2);

        // R3: overrun
        for (int i = 0; i < 9; i++) send(8'h40 + 8'(i));
        idle(1);
        chk("R3", "level capped", int'(fifo_level), 8);
        chk("R3", "overrun set", int'(overrun), 1);
        for (int i = 0; i < 8; i++) rd();
        idle(2);
        chk("R2", "last of full buffer", int'(rd_data), 8'h47);

        finish_run();
    end
endmodule